// File: doc/BRIEF.md
# Linked-List DMA Address Sequencer

This block walks a chain of seven-word transfer descriptors that sit in a word-addressed local data memory. Software writes the address of the first descriptor into the start input while the block is idle. The sequencer then reads each descriptor one word per cycle through a synchronous read port with one cycle of latency. It decides from the control word and the count word whether the transfer runs. When it does, the block emits one local-memory word address per cycle toward a data mover, each tagged with a direction bit and a memory-region code.

Two address patterns are supported. The strided pattern steps from the base address by a fixed step. The interleaved pattern visits every channel of one block before it moves to the next block. Transfers with a rejected sample format, a count that the format does not allow, an empty count, or an inbound request to an output-only buffer produce no addresses, and the chain simply continues. The walk stops after the descriptor that carries the end-of-list mark. At that point a sticky flag in the status output is set and the busy output falls.

Top module: `dma_chain_seq`

## Requirements
- R1: A pulse on `start_we` while `busy` is low begins a walk at `start_addr`, and `busy` is high from the next cycle until the walk ends. A pulse on `start_we` while `busy` is high has no effect on the walk.
- R2: Each descriptor is read as seven single-cycle requests at consecutive addresses, starting at the descriptor address. Read data is taken one cycle after each request.
- R3: Descriptor word 0 bits 13:0 give the next descriptor address, and bit 14 set marks the last descriptor. Its transfer, if any, completes before the walk ends.
- R4: When a walk ends, `irq_status` bit 7 is set in the same cycle that `busy` falls, and it stays set until the next accepted start clears it. All other status bits read 0.
- R5: With control-word bit 0 clear, word 2 is a sample count N and word 3 bits 13:0 are a base B. The addresses B + i*S for i = 0..N-1 are emitted in order, where S is control-word bits 23:14 and the sum wraps modulo 2^14.
- R6: With control-word bit 0 set, word 2 bits 3:0 hold the channel count minus one and bits 23:4 hold the block count. The addresses B + b + c*S (mod 2^14) are emitted with b as the outer loop and c as the inner loop.
- R7: Every emitted address carries `xfer_dir` equal to control-word bit 1 (0 = into local memory, 1 = out to buffer).
- R8: A descriptor with control-word bit 1 clear and buffer select (bits 8:5) equal to 2 or 3 emits no addresses, and the walk goes on.
- R9: Sample format (control bits 12:10) values 4, 5 and 7 emit no addresses. In strided mode, format 0 with a count that is not a multiple of 4 emits none, and format 1 with an odd count emits none. Formats 2, 3 and 6 have no count restriction.
- R10: A strided descriptor with count 0, or an interleaved descriptor with block count 0, emits no addresses.
- R11: `xfer_region` is 0 for addresses below 0x1800, 1 for 0x1800–0x27FF, 2 for 0x2800–0x37FF, and 3 above 0x37FF.
- R12: Addresses of one transfer are emitted on consecutive cycles. No address is emitted while a descriptor is being read or while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_we | input | 1 | Write strobe for the first-descriptor address |
| start_addr | input | 14 | Address of the first descriptor |
| desc_rd_en | output | 1 | Descriptor read request |
| desc_rd_addr | output | 14 | Descriptor word address |
| desc_rd_data | input | 24 | Read data, valid one cycle after the request |
| xfer_valid | output | 1 | An address is presented this cycle |
| xfer_addr | output | 14 | Local-memory word address |
| xfer_dir | output | 1 | Transfer direction from the control word |
| xfer_region | output | 2 | Memory region of `xfer_addr` |
| busy | output | 1 | A walk is in progress |
| irq_status | output | 8 | Status; bit 7 is the sticky end-of-list flag |

## Verification
The bench builds the block with its default widths: 14-bit addresses, 24-bit words, a 4-bit channel field and a 10-bit step. Counts are kept small, so that every format code, every buffer select in both directions, and both address patterns are swept with several counts and channel/block shapes. These widths also bring the region boundaries and the 14-bit wrap within reach of short transfers. A multi-descriptor chain with a skipped middle link, and a start pulse issued in the middle of a walk, cover the chaining and the ignored-start behaviour.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_t;

  // descriptor layout
  localparam int DESC_WORDS   = 7;
  localparam int KEEP_WORDS   = 4;
  localparam int LAST_MARK    = 14;
  // control word fields
  localparam int CW_ILV       = 0;
  localparam int CW_DIR       = 1;
  localparam int CW_BUF_LSB   = 5;
  localparam int CW_BUF_W     = 4;
  localparam int CW_FMT_LSB   = 10;
  localparam int CW_FMT_W     = 3;
  localparam int CW_STEP_LSB  = 14;
  // status
  localparam int STAT_W       = 8;
  localparam int STAT_END_BIT = 7;

endpackage

// File: rtl/desc_fetch.sv
module desc_fetch #(
  parameter int AW     = 14,
  parameter int DW     = 24,
  parameter int NWORDS = dma_seq_pkg::DESC_WORDS,
  parameter int KEEP   = dma_seq_pkg::KEEP_WORDS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go,
  input  logic [AW-1:0]            go_addr,
  output logic                     rd_en,
  output logic [AW-1:0]            rd_addr,
  input  logic [DW-1:0]            rd_data,
  output logic [KEEP-1:0][DW-1:0]  words,
  output logic                     done
);
  localparam int IW = $clog2(NWORDS + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(NWORDS);

  logic          active;
  logic [IW-1:0] fidx;
  logic [AW-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      fidx   <= '0;
      done   <= 1'b0;
      base   <= '0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        fidx   <= '0;
        base   <= go_addr;
      end else if (active) begin
        if (fidx == LAST_IDX) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          fidx <= fidx + 1'b1;
        end
      end
    end
  end

  // data for request k arrives while fidx == k+1
  for (genvar k = 0; k < KEEP; k++) begin : g_cap
    always_ff @(posedge clk) begin
      if (active && fidx == IW'(k + 1))
        words[k] <= rd_data;
    end
  end

  assign rd_en   = active && (fidx < LAST_IDX);
  assign rd_addr = base + AW'(fidx);

endmodule

// File: rtl/xfer_decode.sv
module xfer_decode #(
  parameter int DW     = 24,
  parameter int CH_W   = 4,
  parameter int STEP_W = 10
) (
  input  logic [DW-1:0]       ctrl,
  input  logic [DW-1:0]       count,
  output logic                ilv,
  output logic                dir,
  output logic                skip,
  output logic [STEP_W-1:0]   step,
  output logic [DW-1:0]       inner_n,
  output logic [DW-CH_W-1:0]  outer_n
);
  import dma_seq_pkg::*;

  localparam int OW = DW - CH_W;

  logic [CW_FMT_W-1:0] fmt;
  logic [CW_BUF_W-1:0] bsel;
  logic                fmt_bad, len_bad, empty, out_only;
  logic                unused_ctrl;

  always_comb begin
    ilv  = ctrl[CW_ILV];
    dir  = ctrl[CW_DIR];
    fmt  = ctrl[CW_FMT_LSB +: CW_FMT_W];
    bsel = ctrl[CW_BUF_LSB +: CW_BUF_W];
    step = ctrl[CW_STEP_LSB +: STEP_W];

    fmt_bad  = (fmt == 3'd4) || (fmt == 3'd5) || (fmt == 3'd7);
    len_bad  = ((fmt == 3'd0) && (count[1:0] != 2'b00)) ||
               ((fmt == 3'd1) && count[0]);
    empty    = ilv ? (count[DW-1:CH_W] == '0) : (count == '0);
    out_only = !dir && ((bsel == 4'd2) || (bsel == 4'd3));
    skip     = fmt_bad || (!ilv && len_bad) || empty || out_only;

    if (ilv) begin
      inner_n = DW'(count[CH_W-1:0]) + DW'(1);
      outer_n = count[DW-1:CH_W];
    end else begin
      inner_n = count;
      outer_n = OW'(1);
    end
  end

  assign unused_ctrl = ^{ctrl[4:2], ctrl[9], ctrl[13]};

endmodule

// File: rtl/addr_gen.sv
module addr_gen #(
  parameter int AW     = 14,
  parameter int DW     = 24,
  parameter int CH_W   = 4,
  parameter int STEP_W = 10,
  parameter int X_END  = 'h1800,
  parameter int Y_END  = 'h2800,
  parameter int P_END  = 'h3800
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                ilv,
  input  logic                dir,
  input  logic [AW-1:0]       base,
  input  logic [STEP_W-1:0]   step,
  input  logic [DW-1:0]       inner_n,
  input  logic [DW-CH_W-1:0]  outer_n,
  output logic                out_valid,
  output logic [AW-1:0]       out_addr,
  output logic                out_dir,
  output logic [1:0]          out_region,
  output logic                done
);
  localparam int OW = DW - CH_W;
  localparam logic [AW:0] XE = (AW + 1)'(X_END);
  localparam logic [AW:0] YE = (AW + 1)'(Y_END);
  localparam logic [AW:0] PE = (AW + 1)'(P_END);

  function automatic logic [1:0] region_of(input logic [AW-1:0] a);
    if ({1'b0, a} < XE)      return 2'd0;
    else if ({1'b0, a} < YE) return 2'd1;
    else if ({1'b0, a} < PE) return 2'd2;
    else                     return 2'd3;
  endfunction

  logic              run;
  logic              ilv_q, dir_q;
  logic [AW-1:0]     row, acc, istep, ostep;
  logic [DW-1:0]     in_i, in_n_q;
  logic [OW-1:0]     out_i, out_n_q;
  logic              in_last, out_last;

  assign in_last  = (in_i == in_n_q - 1'b1);
  assign out_last = (out_i == out_n_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      out_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      if (load) begin
        run <= 1'b1;
      end else if (run) begin
        out_valid <= 1'b1;
        if (in_last && out_last) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      ilv_q   <= ilv;
      dir_q   <= dir;
      row     <= base;
      acc     <= base;
      istep   <= AW'(step);
      ostep   <= AW'(ilv);
      in_i    <= '0;
      out_i   <= '0;
      in_n_q  <= inner_n;
      out_n_q <= outer_n;
    end else if (run) begin
      out_addr   <= acc;
      out_dir    <= dir_q;
      out_region <= region_of(acc);
      if (in_last) begin
        in_i <= '0;
        if (!out_last) begin
          out_i <= out_i + 1'b1;
          row   <= row + ostep;
          acc   <= row + ostep;
        end
      end else begin
        in_i <= in_i + 1'b1;
        acc  <= acc + istep;
      end
    end
  end

  AST_STRIDE_STEP: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(out_valid) && !ilv_q |-> out_addr == $past(out_addr) + istep); // R5
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(out_valid) |-> $stable(out_dir)); // R7
  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> out_valid); // R12

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int AW     = 14,
  parameter int DW     = 24,
  parameter int CH_W   = 4,
  parameter int STEP_W = 10,
  parameter int X_END  = 'h1800,
  parameter int Y_END  = 'h2800,
  parameter int P_END  = 'h3800
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  output logic          desc_rd_en,
  output logic [AW-1:0] desc_rd_addr,
  input  logic [DW-1:0] desc_rd_data,
  output logic          xfer_valid,
  output logic [AW-1:0] xfer_addr,
  output logic          xfer_dir,
  output logic [1:0]    xfer_region,
  output logic          busy,
  output logic [7:0]    irq_status
);
  import dma_seq_pkg::*;

  localparam int OW = DW - CH_W;

  seq_state_t                   state;
  logic                         end_irq;
  logic                         last_q;
  logic [AW-1:0]                next_q;
  logic [KEEP_WORDS-1:0][DW-1:0] words;
  logic                         f_done, g_done, go, load;
  logic [AW-1:0]                go_addr;
  logic                         d_ilv, d_dir, d_skip, w_last;
  logic [STEP_W-1:0]            d_step;
  logic [DW-1:0]                d_inner;
  logic [OW-1:0]                d_outer;
  logic                         unused_words;

  assign w_last = words[0][LAST_MARK];

  desc_fetch #(.AW(AW), .DW(DW), .NWORDS(DESC_WORDS), .KEEP(KEEP_WORDS)) u_fetch (
    .clk(clk), .rst(rst), .go(go), .go_addr(go_addr),
    .rd_en(desc_rd_en), .rd_addr(desc_rd_addr), .rd_data(desc_rd_data),
    .words(words), .done(f_done)
  );

  xfer_decode #(.DW(DW), .CH_W(CH_W), .STEP_W(STEP_W)) u_dec (
    .ctrl(words[1]), .count(words[2]),
    .ilv(d_ilv), .dir(d_dir), .skip(d_skip), .step(d_step),
    .inner_n(d_inner), .outer_n(d_outer)
  );

  addr_gen #(.AW(AW), .DW(DW), .CH_W(CH_W), .STEP_W(STEP_W),
             .X_END(X_END), .Y_END(Y_END), .P_END(P_END)) u_gen (
    .clk(clk), .rst(rst), .load(load), .ilv(d_ilv), .dir(d_dir),
    .base(words[3][AW-1:0]), .step(d_step), .inner_n(d_inner), .outer_n(d_outer),
    .out_valid(xfer_valid), .out_addr(xfer_addr), .out_dir(xfer_dir),
    .out_region(xfer_region), .done(g_done)
  );

  always_comb begin
    go      = 1'b0;
    load    = 1'b0;
    go_addr = next_q;
    unique case (state)
      ST_IDLE: begin
        go      = start_we;
        go_addr = start_addr;
      end
      ST_FETCH: begin
        go_addr = words[0][AW-1:0];
        if (f_done) begin
          load = !d_skip;
          go   = d_skip && !w_last;
        end
      end
      ST_RUN:  go = g_done && !last_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      end_irq <= 1'b0;
      last_q  <= 1'b0;
      next_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_we) begin
          state   <= ST_FETCH;
          end_irq <= 1'b0;
        end
        ST_FETCH: if (f_done) begin
          last_q <= w_last;
          next_q <= words[0][AW-1:0];
          if (!d_skip) begin
            state <= ST_RUN;
          end else if (w_last) begin
            state   <= ST_IDLE;
            end_irq <= 1'b1;
          end
        end
        ST_RUN: if (g_done) begin
          if (last_q) begin
            state   <= ST_IDLE;
            end_irq <= 1'b1;
          end else begin
            state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    irq_status = '0;
    irq_status[STAT_END_BIT] = end_irq;
  end

  assign unused_words = ^{words[0], words[3]};

  AST_FETCH_SEQ: assert property (@(posedge clk) disable iff (rst)
    desc_rd_en && $past(desc_rd_en) |-> desc_rd_addr == $past(desc_rd_addr) + 1'b1); // R2
  AST_END_FLAG: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq_status[7]); // R4
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start_we && !busy |=> busy && !irq_status[7]); // R1
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> !desc_rd_en && busy); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !desc_rd_en); // R12

endmodule

// File: tb/test_dma_chain_seq.sv
module test_dma_chain_seq;
  localparam int AW = 14;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_we = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          desc_rd_en;
  logic [AW-1:0] desc_rd_addr;
  logic [DW-1:0] desc_rd_data = '0;
  logic          xfer_valid;
  logic [AW-1:0] xfer_addr;
  logic          xfer_dir;
  logic [1:0]    xfer_region;
  logic          busy;
  logic [7:0]    irq_status;

  always #2 clk = ~clk;

  dma_chain_seq i_dma_chain_seq (
    .clk(clk), .rst(rst), .start_we(start_we), .start_addr(start_addr),
    .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr), .desc_rd_data(desc_rd_data),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_dir(xfer_dir),
    .xfer_region(xfer_region), .busy(busy), .irq_status(irq_status)
  );

  logic [DW-1:0] mem [0:255];
  always @(posedge clk) if (desc_rd_en) desc_rd_data <= mem[desc_rd_addr[7:0]];

  int got_a[$], got_d[$], got_r[$], got_rd[$];
  int exp_a[$], exp_d[$], exp_rd[$];
  int checks = 0, errors = 0, overlap = 0, cycles = 0;

  always @(negedge clk) if (!rst) begin
    if (xfer_valid) begin
      got_a.push_back(int'(xfer_addr));
      got_d.push_back(int'(xfer_dir));
      got_r.push_back(int'(xfer_region));
    end
    if (desc_rd_en) got_rd.push_back(int'(desc_rd_addr));
    if (xfer_valid && desc_rd_en) overlap++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mk_ctrl(int ilv, int dir, int bsel, int fmt, int step, int extra);
    return (step << 14) | (fmt << 10) | (bsel << 5) | (dir << 1) | ilv | extra;
  endfunction

  task automatic put_desc(int a, int nxt, bit last, int ctrl, int cnt, int base);
    mem[a]     = DW'(nxt | (last ? (1 << 14) : 0));
    mem[a + 1] = DW'(ctrl);
    mem[a + 2] = DW'(cnt);
    mem[a + 3] = DW'(base);
    mem[a + 4] = 24'hABCDEF;
    mem[a + 5] = 24'h13579B;
    mem[a + 6] = 24'hFFFFFF;
  endtask

  function automatic int region_exp(int a);
    if (a < 'h1800) return 0;
    if (a < 'h2800) return 1;
    if (a < 'h3800) return 2;
    return 3;
  endfunction

  task automatic build_exp(int first);
    int a = first;
    for (int guard = 0; guard < 16; guard++) begin
      int ctrl, cw, base, ilv, dir, bsel, fmt, step;
      bit skip;
      for (int k = 0; k < 7; k++) exp_rd.push_back(a + k);
      ctrl = int'(mem[a + 1]); cw = int'(mem[a + 2]); base = int'(mem[a + 3]) & 'h3FFF;
      ilv = ctrl & 1; dir = (ctrl >> 1) & 1; bsel = (ctrl >> 5) & 15;
      fmt = (ctrl >> 10) & 7; step = (ctrl >> 14) & 'h3FF;
      skip = (fmt == 4) || (fmt == 5) || (fmt == 7);
      if (!ilv && fmt == 0 && (cw % 4) != 0) skip = 1;
      if (!ilv && fmt == 1 && (cw % 2) != 0) skip = 1;
      if (dir == 0 && (bsel == 2 || bsel == 3)) skip = 1;
      if (ilv ? ((cw >> 4) == 0) : (cw == 0)) skip = 1;
      if (!skip) begin
        if (!ilv) begin
          for (int i = 0; i < cw; i++) begin
            exp_a.push_back((base + i * step) & 'h3FFF); exp_d.push_back(dir);
          end
        end else begin
          for (int b = 0; b < (cw >> 4); b++)
            for (int c = 0; c <= (cw & 15); c++) begin
              exp_a.push_back((base + b + c * step) & 'h3FFF); exp_d.push_back(dir);
            end
        end
      end
      if (mem[a][14]) break;
      a = int'(mem[a][13:0]);
    end
  endtask

  task automatic run_chain(int first, string tag, bit poke);
    int n = 0;
    got_a.delete(); got_d.delete(); got_r.delete(); got_rd.delete();
    exp_a.delete(); exp_d.delete(); exp_rd.delete();
    overlap = 0;
    build_exp(first);
    @(negedge clk); start_we = 1'b1; start_addr = AW'(first);
    @(negedge clk); start_we = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    chk(irq_status == 8'h00, "R4 flag cleared by start", int'(irq_status), 0);
    while (busy && n < 5000) begin
      @(negedge clk); n++;
      if (poke && n == 3) begin start_we = 1'b1; start_addr = AW'('h80); end
      if (poke && n == 4) start_we = 1'b0;
    end
    start_we = 1'b0;
    chk(!busy, "R1 walk completes", int'(busy), 0);
    chk(irq_status == 8'h80, "R4 end flag", int'(irq_status), 'h80);
    chk(got_rd.size() == exp_rd.size(), "R2 read count", got_rd.size(), exp_rd.size());
    for (int i = 0; i < exp_rd.size() && i < got_rd.size(); i++)
      chk(got_rd[i] == exp_rd[i], "R2 read address", got_rd[i], exp_rd[i]);
    chk(got_a.size() == exp_a.size(), {tag, " address count"}, got_a.size(), exp_a.size());
    for (int i = 0; i < exp_a.size() && i < got_a.size(); i++) begin
      chk(got_a[i] == exp_a[i], {tag, " address"}, got_a[i], exp_a[i]);
      chk(got_d[i] == exp_d[i], "R7 direction", got_d[i], exp_d[i]);
      chk(got_r[i] == region_exp(exp_a[i]), "R11 region", got_r[i], region_exp(exp_a[i]));
    end
    chk(overlap == 0, "R12 no address during fetch", overlap, 0);
    repeat (2) @(negedge clk);
    chk(xfer_valid == 1'b0 && !busy, "R12 quiet when idle", int'(xfer_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(irq_status == 8'h00, "R4 reset status", int'(irq_status), 0);
    chk(xfer_valid == 1'b0, "R12 reset valid", int'(xfer_valid), 0);
    chk(desc_rd_en == 1'b0, "R2 reset read", int'(desc_rd_en), 0);

    // R5 R6 R9 R10: format x count x direction x pattern sweep
    for (int ilv = 0; ilv < 2; ilv++)
      for (int fmt = 0; fmt < 8; fmt++)
        for (int dir = 0; dir < 2; dir++)
          for (int n = 0; n < 6; n++) begin
            int cw = ilv ? (((n % 3) << 4) | (n / 2)) : n;
            put_desc('h10, 0, 1, mk_ctrl(ilv, dir, 0, fmt, 5 + n, (n & 1) << 4), cw,
                     'h100 * fmt + 'h20);
            run_chain('h10, ilv ? "R6" : "R5/R9/R10", 0);
          end

    // R8: every buffer select in both directions
    for (int bsel = 0; bsel < 16; bsel++)
      for (int dir = 0; dir < 2; dir++) begin
        put_desc('h10, 0, 1, mk_ctrl(0, dir, bsel, 2, 1, 0), 3, 'h1000);
        run_chain('h10, "R8", 0);
      end

    // R3: three links, middle one skipped by format
    put_desc('h30, 'h40, 0, mk_ctrl(0, 1, 1, 3, 7, 0), 5, 'h200);
    put_desc('h40, 'h50, 0, mk_ctrl(0, 1, 0, 5, 1, 0), 4, 'h300);
    put_desc('h50, 'h00, 1, mk_ctrl(1, 0, 0, 6, 16, 0), (3 << 4) | 2, 'h400);
    run_chain('h30, "R3", 0);

    // R3: skipped last link ends the walk
    put_desc('h30, 'h40, 0, mk_ctrl(0, 0, 0, 2, 2, 0), 2, 'h500);
    put_desc('h40, 'h00, 1, mk_ctrl(0, 0, 3, 2, 2, 0), 2, 'h600);
    run_chain('h30, "R3", 0);

    // R11 region boundaries and R5 wrap
    put_desc('h60, 'h68, 0, mk_ctrl(0, 1, 0, 2, 1, 0), 4, 'h17FE);
    put_desc('h68, 'h70, 0, mk_ctrl(0, 1, 0, 2, 1, 0), 2, 'h27FF);
    put_desc('h70, 'h78, 0, mk_ctrl(0, 1, 0, 2, 1, 0), 4, 'h37FE);
    put_desc('h78, 'h00, 1, mk_ctrl(0, 0, 0, 6, 3, 0), 3, 'h3FFE);
    run_chain('h60, "R11/R5", 0);

    // R1: start while busy is ignored
    put_desc('h80, 'h00, 1, mk_ctrl(0, 1, 0, 2, 9, 0), 2, 'h900);
    put_desc('h20, 'h00, 1, mk_ctrl(0, 1, 0, 2, 2, 0), 8, 'h700);
    run_chain('h20, "R1", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule